// File: doc/BRIEF.md
# Flash Disk Window Mapper

This block places an 8 KB window at the top of a 16-bit processor address space, at 0xE000 to 0xFFFF, directly above 56 KB of RAM. It steers every memory access that lands in that window onto one 8 KB page of one of up to four 256 KB flash disks. Software chooses the page and the disk by writing a single map register through an I/O port. Sector data can then be read or written with ordinary memory instructions, with no programmed-I/O transfer loop.

The map register holds a 5-bit page number and a 2-bit disk number. The window offset, which is address bits 12..0, is joined below the page number to form an 18-bit byte offset into the selected device. One select line per disk is asserted only while a memory strobe is active inside the window. With 128-byte sectors and 16 sectors per track, each page covers four tracks, and 32 pages cover a whole device. The register can be read back through the same port.

Top module: `flash_window_mapper`

## Requirements
- R1: After reset the map register is 0x00, meaning disk 0 and page 0. A window access at 0xE123 then asserts disk select bit 0 and gives flash address 0x00123.
- R2: An I/O write strobe with address bits 7..0 equal to 0x44 loads the map register from the data bus at that clock edge. The new mapping applies from the next cycle.
- R3: The map register keeps its value through I/O writes to any other port and through memory writes at any address, including 0x0044.
- R4: Window hit is high exactly when a memory read or memory write strobe is active and the address is 0xE000 or higher. It is low for 0xDFFF and below, and it is low when no memory strobe is active.
- R5: The flash address is {map[4:0], address[12:0]}, an 18-bit byte offset. The page number occupies bits 17..13.
- R6: During a window hit, only disk select bit map[6:5] is high. All disk selects are low when there is no hit.
- R7: Data bit 7 of a map write is ignored. It does not affect the page or the disk, and it reads back as 0.
- R8: An I/O read strobe at port 0x44 returns {0, map[6:0]} on the read data bus. At all other times the read data bus is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address; bits 7..0 carry the port number during I/O cycles |
| cpu_wdata | input | 8 | Processor write data |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| cpu_rdata | output | 8 | Map register read-back, 0 when not addressed |
| flash_addr | output | 18 | Byte offset into the selected flash disk |
| disk_sel | output | 4 | One active-high select per disk |
| win_hit | output | 1 | A memory access falls inside the window |

## Verification
The assertions assume that the I/O strobes and the memory strobes are never active in the same cycle. They also assume that the address and data are stable for the whole cycle in which a strobe is high, as on a real processor bus. The stimulus drives exactly one kind of strobe per cycle. It changes the bus only at the falling clock edge, so each map write sees a single rising edge with a steady port number and data byte. Window accesses are issued at the boundary addresses 0xDFFF, 0xE000 and 0xFFFF, as well as at inner addresses, for every disk number.

// File: rtl/flash_window_mapper.sv
`timescale 1ns/1ps
module flash_window_mapper #(
  parameter int ADDR_W    = 16,
  parameter int WIN_BITS  = 13,
  parameter int PAGE_BITS = 5,
  parameter int DISK_BITS = 2,
  parameter int DATA_W    = 8,
  parameter logic [7:0] MAP_PORT = 8'h44,
  localparam int NUM_DISKS = 1 << DISK_BITS,
  localparam int MAP_W     = PAGE_BITS + DISK_BITS,
  localparam int FLASH_W   = PAGE_BITS + WIN_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic               mem_rd,
  input  logic               mem_wr,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic [FLASH_W-1:0] flash_addr,
  output logic [NUM_DISKS-1:0] disk_sel,
  output logic               win_hit
);

  logic [MAP_W-1:0] map_q;
  logic             port_hit;
  logic             in_win;
  logic [DISK_BITS-1:0] disk_no;

  assign port_hit = (cpu_addr[7:0] == MAP_PORT);
  assign in_win   = &cpu_addr[ADDR_W-1:WIN_BITS];
  assign disk_no  = map_q[MAP_W-1:PAGE_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      map_q <= '0;
    else if (io_wr && port_hit)
      map_q <= cpu_wdata[MAP_W-1:0];
  end

  assign win_hit    = (mem_rd || mem_wr) && in_win;
  assign flash_addr = {map_q[PAGE_BITS-1:0], cpu_addr[WIN_BITS-1:0]};
  assign cpu_rdata  = (io_rd && port_hit) ? {{(DATA_W-MAP_W){1'b0}}, map_q} : '0;

  for (genvar d = 0; d < NUM_DISKS; d++) begin : g_sel
    assign disk_sel[d] = win_hit && (disk_no == DISK_BITS'(d));
  end

  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disk_sel));

  assert_sel_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disk_sel != '0) == win_hit);

  assert_no_hit_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_win || !(mem_rd || mem_wr)) |-> !win_hit);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && port_hit) |=> (flash_addr[FLASH_W-1:WIN_BITS] == $past(cpu_wdata[PAGE_BITS-1:0])));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && port_hit) |=> $stable(flash_addr[FLASH_W-1:WIN_BITS]));

  assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && port_hit) |-> (cpu_rdata == '0));

endmodule

// File: tb/flash_window_mapper_tb_top.sv
`timescale 1ns/1ps
module flash_window_mapper_tb_top;

  typedef struct {
    logic        hit;
    logic [3:0]  sel;
    logic [17:0] fa;
    logic [7:0]  rd;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0, mem_rd = 1'b0, mem_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [17:0] flash_addr;
  logic [3:0]  disk_sel;
  logic        win_hit;

  exp_t        sb_q[$];
  logic [6:0]  model = '0;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  flash_window_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .cpu_rdata(cpu_rdata), .flash_addr(flash_addr), .disk_sel(disk_sel),
    .win_hit(win_hit)
  );

  task automatic io_write(input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    cpu_addr = {port, port}; cpu_wdata = data;
    io_wr = 1; io_rd = 0; mem_rd = 0; mem_wr = 0;
    if (port == 8'h44) model = data[6:0];
  endtask

  task automatic access(input logic [15:0] a, input logic rd, input logic wr,
                        input logic iord, input string req);
    exp_t e;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = 8'hA5;
    io_wr = 0; io_rd = iord; mem_rd = rd; mem_wr = wr;
    e.hit = (rd || wr) && (a >= 16'hE000);
    e.sel = e.hit ? (4'b0001 << model[6:5]) : 4'b0000;
    e.fa  = {model[4:0], a[12:0]};
    e.rd  = (iord && a[7:0] == 8'h44) ? {1'b0, model} : 8'h00;
    e.req = req;
    sb_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #3;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_checks++;
        if (win_hit !== e.hit || disk_sel !== e.sel || flash_addr !== e.fa || cpu_rdata !== e.rd) begin
          n_fail++;
          $display("FAIL %s: got hit=%b sel=%b fa=%h rd=%h, expected hit=%b sel=%b fa=%h rd=%h",
                   e.req, win_hit, disk_sel, flash_addr, cpu_rdata, e.hit, e.sel, e.fa, e.rd);
        end
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    access(16'h0044, 0, 0, 1, "R1");
    access(16'hE123, 1, 0, 0, "R1");
    io_write(8'h44, 8'h25);
    access(16'hE000, 1, 0, 0, "R2");
    access(16'hFFFF, 0, 1, 0, "R5");
    access(16'hDFFF, 1, 0, 0, "R4");
    access(16'hF000, 0, 0, 0, "R4");
    io_write(8'h45, 8'h7F);
    access(16'hE010, 1, 0, 0, "R3");
    @(negedge clk);
    cpu_addr = 16'h0044; cpu_wdata = 8'h13;
    io_wr = 0; io_rd = 0; mem_rd = 0; mem_wr = 1;
    access(16'h0044, 0, 0, 1, "R3");
    io_write(8'h44, 8'hDF);
    access(16'h0044, 0, 0, 1, "R7");
    access(16'hE001, 1, 0, 0, "R7");
    io_write(8'h44, 8'h60);
    access(16'hEABC, 0, 1, 0, "R6");
    access(16'h0040, 0, 0, 1, "R8");
    access(16'h1044, 1, 0, 0, "R8");
    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 32; p += 9) begin
        io_write(8'h44, 8'((d << 5) | p));
        access(16'hE000 + 16'(p * 37), 1, 0, 0, "R6");
        access(16'hFFFE, 0, 1, 0, "R5");
        access(16'hDFFF, 0, 1, 0, "R4");
        access(16'h0044, 0, 0, 1, "R8");
      end
    end
    @(negedge clk);
    io_rd = 0; mem_rd = 0; mem_wr = 0;
    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule